// File: doc/BRIEF.md
# Double-to-Int32 Conversion Unit

This unit turns an IEEE-754 double-precision operand into a signed 32-bit integer. The rounding mode is chosen per operation by a 2-bit field. Finite values that fall outside the int32 range after rounding saturate to the nearest limit, and so do infinities. Every NaN gives a fixed sentinel. For each conversion the unit produces three status pulses for a floating-point status register (invalid conversion, signaling NaN, inexact), a summary pulse, and a 4-bit condition nibble used by the record-form variant of the instruction.

The unit is one pipeline stage. An operand presented with `in_valid` appears on the outputs on the next clock edge, qualified by `out_valid`. The 32-bit integer sits in the low half of a 64-bit destination word, ready for a floating-point register write.

Top module: `dbl_to_i32_conv`

## Requirements
- R1: Any NaN operand (exponent all ones, fraction nonzero) yields low word 0x80000000 and raises `flag_invalid`.
- R2: A signaling NaN (fraction bit 51 clear) also raises `flag_snan`. A quiet NaN (fraction bit 51 set) leaves `flag_snan` low.
- R3: A positive operand whose rounded value exceeds 2147483647 saturates to 0x7FFFFFFF and raises `flag_invalid`. This includes +infinity. The range test is made after rounding.
- R4: A negative operand whose rounded value is below -2147483648 saturates to 0x80000000 and raises `flag_invalid`. This includes -infinity.
- R5: `rnd_mode` selects the rounding: 2'b00 nearest with ties to even (0.5, 1.5 and 2.5 give 0, 2 and 2), 2'b01 toward zero, 2'b10 toward +infinity, 2'b11 toward -infinity.
- R6: When the rounded integer differs from the operand, `flag_inexact` and `flag_summary` are raised. `flag_inexact` never accompanies `flag_invalid`. `flag_summary` equals invalid OR inexact.
- R7: Bits 63:32 of `result` are always zero.
- R8: With `record_en` high, `cond_nibble` bit 3 is the summary flag, bit 2 is the enabled-exception bit (always 0, since there are no trap enables), bit 1 is the invalid summary, and bit 0 is the overflow bit (always 0). With `record_en` low the nibble is 0.
- R9: Results appear exactly one cycle after `in_valid`, with `out_valid` high. All flags and the nibble are zero in any cycle where `out_valid` is low, and also after reset.
- R10: Zero and subnormal operands convert to 0. A nonzero subnormal raises inexact, except when a directed mode rounds it away from zero to +1 or -1; in that case no inexact is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| operand | input | 64 | binary64 operand bits |
| rnd_mode | input | 2 | Rounding mode select |
| record_en | input | 1 | Record form: load condition nibble |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Zero-extended int32 result |
| flag_invalid | output | 1 | Invalid-conversion pulse |
| flag_snan | output | 1 | Signaling-NaN pulse |
| flag_inexact | output | 1 | Inexact pulse |
| flag_summary | output | 1 | Any-exception summary pulse |
| cond_nibble | output | 4 | Record-form condition field |

## Verification
The hardest cases to hit are the edges of the rounding window. Examples are an operand just below 2^31 that rounding pushes out of range, an operand just below -2^31 that rounding pulls back in range, exact ties, and subnormals under each directed mode. The stimulus builds these operands from explicit bit patterns and from real constants converted to bits. Each one is run through all four rounding modes and compared every clock against a behavioural real-arithmetic model in the bench.

// File: rtl/dbl_to_i32_conv.sv
module dbl_to_i32_conv #(
  parameter int FRAC_W = 52,
  parameter int EXP_W  = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] operand,
  input  logic [1:0]  rnd_mode,
  input  logic        record_en,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        flag_invalid,
  output logic        flag_snan,
  output logic        flag_inexact,
  output logic        flag_summary,
  output logic [3:0]  cond_nibble
);
  localparam int MANT_W = FRAC_W + 1;
  localparam int FPT    = 128;
  localparam int WIDE_W = MANT_W + FPT;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int SH_MAX = 116;

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  assign sgn = operand[63];
  assign ex  = operand[62:FRAC_W];
  assign fr  = operand[FRAC_W-1:0];

  logic is_top, is_nan, is_inf, is_sub;
  assign is_top = &ex;
  assign is_nan = is_top & (|fr);
  assign is_inf = is_top & ~(|fr);
  assign is_sub = (ex == '0);

  logic signed [EXP_W+1:0] unb;
  assign unb = $signed({2'b00, ex}) - (EXP_W+2)'(BIAS);

  logic big;
  assign big = ~is_top & (unb > 31);

  logic [7:0] sh;
  always_comb begin
    if (is_sub || unb < -63) sh = 8'(SH_MAX);
    else if (unb > 31)       sh = 8'd21;
    else                     sh = 8'(52 - unb);
  end

  logic [WIDE_W-1:0] wide;
  assign wide = {~is_sub, fr, {FPT{1'b0}}} >> sh;

  logic [31:0] mag;
  logic        g, st;
  assign mag = wide[FPT+31:FPT];
  assign g   = wide[FPT-1];
  assign st  = |wide[FPT-2:0];

  logic inc;
  always_comb begin
    case (rnd_mode)
      2'b00:   inc = g & (st | mag[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = ~sgn & (g | st);
      default: inc = sgn & (g | st);
    endcase
  end

  logic [32:0] rmag;
  assign rmag = {1'b0, mag} + 33'(inc);

  logic ovf_p, ovf_n, inv, inx;
  assign ovf_p = ~is_nan & ~sgn & (big | is_inf | (rmag > 33'h0_7FFF_FFFF));
  assign ovf_n = ~is_nan &  sgn & (big | is_inf | (rmag > 33'h0_8000_0000));
  assign inv   = is_nan | ovf_p | ovf_n;
  assign inx   = ~inv & (g | st) & ~(is_sub & inc);

  logic [31:0] ival;
  always_comb begin
    if (is_nan || ovf_n) ival = 32'h8000_0000;
    else if (ovf_p)      ival = 32'h7FFF_FFFF;
    else if (sgn)        ival = -rmag[31:0];
    else                 ival = rmag[31:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      result       <= '0;
      flag_invalid <= 1'b0;
      flag_snan    <= 1'b0;
      flag_inexact <= 1'b0;
      flag_summary <= 1'b0;
      cond_nibble  <= '0;
    end else begin
      out_valid    <= in_valid;
      flag_invalid <= in_valid & inv;
      flag_snan    <= in_valid & is_nan & ~fr[FRAC_W-1];
      flag_inexact <= in_valid & inx;
      flag_summary <= in_valid & (inv | inx);
      cond_nibble  <= (in_valid & record_en) ? {inv | inx, 1'b0, inv, 1'b0} : 4'h0;
      if (in_valid) result <= {32'h0, ival};
    end
  end
endmodule

module dbl_to_i32_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] operand,
  input logic [1:0]  rnd_mode,
  input logic        record_en,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        flag_invalid,
  input logic        flag_snan,
  input logic        flag_inexact,
  input logic        flag_summary,
  input logic [3:0]  cond_nibble
);
  logic nan_in, inf_in;
  assign nan_in = (&operand[62:52]) & (|operand[51:0]);
  assign inf_in = (&operand[62:52]) & ~(|operand[51:0]);

  assert_nan_sentinel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && nan_in |=> result == 64'h8000_0000 && flag_invalid);
  assert_snan_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && nan_in |=> flag_snan == !$past(operand[51]));
  assert_pos_inf_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && inf_in && !operand[63] |=> result == 64'h7FFF_FFFF && flag_invalid);
  assert_neg_inf_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && inf_in && operand[63] |=> result == 64'h8000_0000 && flag_invalid);
  assert_no_inexact_with_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_invalid && flag_inexact));
  assert_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_summary == (flag_invalid || flag_inexact));
  assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    result[63:32] == 32'h0);
  assert_cond_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !record_en |=> cond_nibble == 4'h0);
  assert_cond_fixed_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_nibble[2] && !cond_nibble[0]);
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !flag_invalid && !flag_snan && !flag_inexact && cond_nibble == 4'h0);
  assert_zero_in_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && operand[62:0] == 63'h0 |=> result == 64'h0 && !flag_summary);
endmodule

bind dbl_to_i32_conv dbl_to_i32_conv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
  .rnd_mode(rnd_mode), .record_en(record_en), .out_valid(out_valid),
  .result(result), .flag_invalid(flag_invalid), .flag_snan(flag_snan),
  .flag_inexact(flag_inexact), .flag_summary(flag_summary),
  .cond_nibble(cond_nibble)
);

// File: tb/dbl_to_i32_conv_bench.sv
module dbl_to_i32_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] operand = '0;
  logic [1:0]  rnd_mode = '0;
  logic        record_en = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic        flag_invalid, flag_snan, flag_inexact, flag_summary;
  logic [3:0]  cond_nibble;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  dbl_to_i32_conv u_dbl_to_i32_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .rnd_mode(rnd_mode), .record_en(record_en), .out_valid(out_valid),
    .result(result), .flag_invalid(flag_invalid), .flag_snan(flag_snan),
    .flag_inexact(flag_inexact), .flag_summary(flag_summary),
    .cond_nibble(cond_nibble)
  );

  logic        e_valid = 1'b0;
  logic [63:0] e_res = '0;
  logic        e_inv = 1'b0, e_sn = 1'b0, e_inx = 1'b0, e_fx = 1'b0;
  logic [3:0]  e_cond = '0;
  string       e_tag = "R9";

  task automatic model(input logic [63:0] op, input logic [1:0] md, input logic rec,
                       output logic [31:0] r, output logic inv, output logic sn,
                       output logic inx, output string tag);
    real v, fl, frc, rr;
    logic [10:0] e;
    logic [51:0] f;
    e = op[62:52];
    f = op[51:0];
    inv = 0; sn = 0; inx = 0; r = 0; tag = "R5";
    if (e == 11'h7FF && f != 0) begin
      r = 32'h8000_0000; inv = 1; sn = !f[51]; tag = f[51] ? "R1" : "R2";
    end else begin
      v = $bitstoreal(op);
      if (v >= 4294967296.0) begin
        r = 32'h7FFF_FFFF; inv = 1; tag = "R3";
      end else if (v <= -4294967296.0) begin
        r = 32'h8000_0000; inv = 1; tag = "R4";
      end else begin
        fl = $floor(v);
        frc = v - fl;
        case (md)
          2'b00: begin
            if (frc > 0.5) rr = fl + 1.0;
            else if (frc < 0.5) rr = fl;
            else rr = (longint'(fl) % 2 == 0) ? fl : fl + 1.0;
          end
          2'b01: rr = (v < 0.0) ? $ceil(v) : fl;
          2'b10: rr = $ceil(v);
          default: rr = fl;
        endcase
        if (rr > 2147483647.0) begin
          r = 32'h7FFF_FFFF; inv = 1; tag = "R3";
        end else if (rr < -2147483648.0) begin
          r = 32'h8000_0000; inv = 1; tag = "R4";
        end else begin
          r = 32'(longint'(rr));
          inx = (rr != v);
          if (e == 0) begin
            tag = "R10";
            if (rr != 0.0) inx = 0;
          end
        end
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= 0; e_res <= 0; e_inv <= 0; e_sn <= 0; e_inx <= 0; e_fx <= 0;
      e_cond <= 0; e_tag <= "R9";
    end else begin
      logic [31:0] r;
      logic inv, sn, inx;
      string tag;
      e_valid <= in_valid;
      if (in_valid) begin
        model(operand, rnd_mode, record_en, r, inv, sn, inx, tag);
        e_res <= {32'h0, r};
        e_inv <= inv; e_sn <= sn; e_inx <= inx; e_fx <= inv | inx;
        e_cond <= record_en ? {inv | inx, 1'b0, inv, 1'b0} : 4'h0;
        e_tag <= tag;
      end else begin
        e_inv <= 0; e_sn <= 0; e_inx <= 0; e_fx <= 0; e_cond <= 0; e_tag <= "R9";
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    check("R9 valid", 64'(out_valid), 64'(e_valid));
    check("R1 invalid flag", 64'(flag_invalid), 64'(e_inv));
    check("R2 snan flag", 64'(flag_snan), 64'(e_sn));
    check("R6 inexact flag", 64'(flag_inexact), 64'(e_inx));
    check("R6 summary flag", 64'(flag_summary), 64'(e_fx));
    check("R8 cond nibble", 64'(cond_nibble), 64'(e_cond));
    if (out_valid) begin
      check({e_tag, " result"}, result, e_res);
      check("R7 upper half", 64'(result[63:32]), 64'h0);
    end
  end

  task automatic send(input logic [63:0] op, input logic [1:0] md, input logic rec);
    @(negedge clk);
    in_valid = 1; operand = op; rnd_mode = md; record_en = rec;
  endtask

  task automatic all_modes(input real v);
    for (int m = 0; m < 4; m++) send($realtobits(v), 2'(m), m[0]);
  endtask

  task automatic all_modes_bits(input logic [63:0] b);
    for (int m = 0; m < 4; m++) send(b, 2'(m), ~m[0]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; operand = 64'hDEAD_BEEF_0000_0001;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    send($realtobits(0.5), 2'b00, 1);
    send($realtobits(1.5), 2'b00, 1);
    send($realtobits(2.5), 2'b00, 0);
    send($realtobits(-2.5), 2'b00, 1);
    all_modes(2.7);
    all_modes(-2.7);
    all_modes(-0.3);
    all_modes(12345.0);
    all_modes(2147483647.6);
    all_modes(2147483647.4);
    all_modes(-2147483648.4);
    all_modes(-2147483648.6);
    all_modes(2147483648.0);
    all_modes(3.0e9);
    all_modes(-3.0e9);
    all_modes(1.0e300);
    all_modes(-1.0e300);
    all_modes_bits(64'h7FF8_0000_0000_0000);
    all_modes_bits(64'hFFF8_0000_0000_0001);
    all_modes_bits(64'h7FF0_0000_0000_0001);
    all_modes_bits(64'h7FF4_0000_0000_0000);
    all_modes_bits(64'h7FF0_0000_0000_0000);
    all_modes_bits(64'hFFF0_0000_0000_0000);
    all_modes_bits(64'h0000_0000_0000_0000);
    all_modes_bits(64'h8000_0000_0000_0000);
    all_modes_bits(64'h0000_0000_0000_0001);
    all_modes_bits(64'h8000_0000_0000_0001);
    all_modes_bits(64'h000F_FFFF_FFFF_FFFF);
    idle(1);
    all_modes(1.0e-200);
    all_modes(-0.5);
    all_modes(0.75);
    idle(3);
    for (int k = -40; k <= 40; k++) all_modes(real'(k) * 0.25 + 0.125 * real'(k % 3));
    idle(4);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule